// File: doc/BRIEF.md
# DMA Channel Register and Status Logic

This block holds the programming state of a single channel of a memory-to-peripheral DMA controller. Software writes a control word, a base address and a block descriptor through a small register bus. From those contents the block derives whether the channel is currently armed, and how many units the transfer engine should move under the selected synchronisation mode.

The transfer engine sits outside the block. It reads `active_o`, `xfer_len_o` and `len_valid_o`, and pulses `done_i` when the channel's work is finished. That pulse disarms the channel by clearing its enable and start bits. Read data comes back one clock after the address is presented. The status outputs are combinational from the stored registers, so they reflect a write in the cycle that follows it.

Top module: `dma_chan_regs`

## Requirements
- R1: After a synchronous reset all three registers read as zero. The status outputs are then inactive, a length of 0, and length-valid high, because the reset sync mode is manual.
- R2: Control register (address 0) field positions: direction bit 0, address step bit 1, chop enable bit 8, sync mode bits 10:9 (0 manual, 1 request, 2 linked list, 3 reserved), chop DMA window bits 18:16, chop CPU window bits 22:20, enable bit 24, start trigger bit 28, spare bits 30:29. These bits read back as written and every other bit reads as zero (readable mask 0x71770703).
- R3: The base register (address 1) keeps bits 23:0 of a write. Bits 31:24 always read as zero.
- R4: The block register (address 2) holds size in bits 15:0 and count in bits 31:16, and reads back exactly as written.
- R5: `active_o` is high when enable is set and the mode condition holds. In manual mode the condition is the trigger bit. In request and linked-list mode it is always true. In reserved mode 3 the channel is never active.
- R6: In manual mode `xfer_len_o` equals the block size and `len_valid_o` is high.
- R7: In request mode `xfer_len_o` equals size times count, kept to 32 bits, and `len_valid_o` is high.
- R8: In linked-list mode and in reserved mode 3, `len_valid_o` is low and `xfer_len_o` is 0.
- R9: A `done_i` pulse clears the enable and trigger bits at the next edge and leaves every other control field unchanged.
- R10: When a control write and `done_i` fall in the same cycle, the other fields take the written value and enable and trigger end up cleared.
- R11: Address 3 reads as zero, and a write to it changes no register.
- R12: Read data appears one cycle after the address. It shows the register contents from before any write in that same cycle. The status outputs reflect a write in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr_i | input | 2 | Register select (0 control, 1 base, 2 block, 3 unused) |
| reg_we_i | input | 1 | Write enable |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| done_i | input | 1 | Completion strobe from the transfer engine |
| active_o | output | 1 | Channel armed |
| xfer_len_o | output | 32 | Transfer length for the current mode |
| len_valid_o | output | 1 | Length is defined for the current mode |

## Verification
The assertions check several rules on every cycle. A done strobe disarms the channel, and a same-cycle write cannot rearm it. Read-backs of the control and base registers never show reserved or upper bits. A block write lands unchanged. Reserved mode never activates and never reports a length. Which length is computed for which mode, and the exact product, are shown only by the bench scenarios. The same holds for the full read path and the ignored writes to address 3. The bench compares every cycle of a random register, strobe and address mix against its own model.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 2;
  localparam int BASE_W  = 24;
  localparam int SIZE_W  = 16;
  localparam int WIN_W   = 3;
  localparam logic [DATA_W-1:0] CTRL_MASK = 32'h7177_0703;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 2'd0,
    A_BASE = 2'd1,
    A_BLK  = 2'd2,
    A_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    SM_MANUAL  = 2'd0,
    SM_REQUEST = 2'd1,
    SM_LIST    = 2'd2,
    SM_RSVD    = 2'd3
  } sync_e;

  typedef struct packed {
    logic             to_dev;
    logic             step_dn;
    logic             chop;
    sync_e            sync;
    logic [WIN_W-1:0] win_dma;
    logic [WIN_W-1:0] win_cpu;
    logic             en;
    logic             start;
    logic [1:0]       spare;
  } ctrl_t;

  function automatic logic [DATA_W-1:0] ctrl_pack(ctrl_t c);
    logic [DATA_W-1:0] w;
    w        = '0;
    w[0]     = c.to_dev;
    w[1]     = c.step_dn;
    w[8]     = c.chop;
    w[10:9]  = c.sync;
    w[18:16] = c.win_dma;
    w[22:20] = c.win_cpu;
    w[24]    = c.en;
    w[28]    = c.start;
    w[30:29] = c.spare;
    return w;
  endfunction

  function automatic ctrl_t ctrl_unpack(logic [DATA_W-1:0] w);
    ctrl_t c;
    c.to_dev  = w[0];
    c.step_dn = w[1];
    c.chop    = w[8];
    c.sync    = sync_e'(w[10:9]);
    c.win_dma = w[18:16];
    c.win_cpu = w[22:20];
    c.en      = w[24];
    c.start   = w[28];
    c.spare   = w[30:29];
    return c;
  endfunction
endpackage

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              done_i,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q;
  ctrl_t ctrl_d;
  logic [DATA_W-1:0] masked;

  assign masked = wdata_i & CTRL_MASK;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_i) ctrl_d = ctrl_unpack(masked);
    if (done_i) begin
      ctrl_d.en    = 1'b0;
      ctrl_d.start = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  // R9 and R10: a done strobe always leaves the channel disarmed
  p_done_disarm_r9: assert property (@(posedge clk) disable iff (rst)
    done_i |=> (!ctrl_q.en && !ctrl_q.start));

  // R9: without a write, done leaves the other fields untouched
  p_done_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (done_i && !wr_i) |=> ($stable(ctrl_q.sync) && $stable(ctrl_q.win_dma) &&
                           $stable(ctrl_q.win_cpu) && $stable(ctrl_q.spare) &&
                           $stable(ctrl_q.to_dev) && $stable(ctrl_q.chop)));
endmodule

// File: rtl/dma_chan_addr.sv
module dma_chan_addr
  import dma_chan_pkg::*;
#(
  parameter int BW = BASE_W,
  parameter int SW = SIZE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          base_wr_i,
  input  logic          blk_wr_i,
  input  logic [BW-1:0] base_wdata_i,
  input  logic [SW-1:0] size_wdata_i,
  input  logic [SW-1:0] count_wdata_i,
  output logic [BW-1:0] base_o,
  output logic [SW-1:0] size_o,
  output logic [SW-1:0] count_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base_o  <= '0;
      size_o  <= '0;
      count_o <= '0;
    end else begin
      if (base_wr_i) base_o <= base_wdata_i;
      if (blk_wr_i) begin
        size_o  <= size_wdata_i;
        count_o <= count_wdata_i;
      end
    end
  end

  // R4: a block write lands unchanged
  p_blk_write_r4: assert property (@(posedge clk) disable iff (rst)
    blk_wr_i |=> (size_o == $past(size_wdata_i) && count_o == $past(count_wdata_i)));
endmodule

// File: rtl/dma_chan_len.sv
module dma_chan_len
  import dma_chan_pkg::*;
#(
  parameter int SW = SIZE_W,
  parameter int LW = DATA_W
) (
  input  sync_e         sync_i,
  input  logic          en_i,
  input  logic          start_i,
  input  logic [SW-1:0] size_i,
  input  logic [SW-1:0] count_i,
  output logic          active_o,
  output logic [LW-1:0] len_o,
  output logic          len_valid_o
);
  localparam int PW = 2 * SW;
  logic [PW-1:0] prod;
  logic          cond;

  assign prod = size_i * count_i;

  always_comb begin
    cond        = 1'b0;
    len_o       = '0;
    len_valid_o = 1'b0;
    unique case (sync_i)
      SM_MANUAL: begin
        cond        = start_i;
        len_o       = LW'(size_i);
        len_valid_o = 1'b1;
      end
      SM_REQUEST: begin
        cond        = 1'b1;
        len_o       = LW'(prod);
        len_valid_o = 1'b1;
      end
      SM_LIST: cond = 1'b1;
      default: cond = 1'b0;
    endcase
  end

  assign active_o = en_i && cond;
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              done_i,
  output logic              active_o,
  output logic [DATA_W-1:0] xfer_len_o,
  output logic              len_valid_o
);
  reg_sel_e          sel;
  ctrl_t             ctrl;
  logic [BASE_W-1:0] base;
  logic [SIZE_W-1:0] size;
  logic [SIZE_W-1:0] count;
  logic [DATA_W-1:0] rd_mux;

  assign sel = reg_sel_e'(reg_addr_i);

  dma_chan_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (reg_we_i && sel == A_CTRL),
    .wdata_i (reg_wdata_i),
    .done_i  (done_i),
    .ctrl_o  (ctrl)
  );

  dma_chan_addr #(.BW(BASE_W), .SW(SIZE_W)) u_addr (
    .clk           (clk),
    .rst           (rst),
    .base_wr_i     (reg_we_i && sel == A_BASE),
    .blk_wr_i      (reg_we_i && sel == A_BLK),
    .base_wdata_i  (reg_wdata_i[BASE_W-1:0]),
    .size_wdata_i  (reg_wdata_i[SIZE_W-1:0]),
    .count_wdata_i (reg_wdata_i[DATA_W-1:SIZE_W]),
    .base_o        (base),
    .size_o        (size),
    .count_o       (count)
  );

  dma_chan_len #(.SW(SIZE_W), .LW(DATA_W)) u_len (
    .sync_i      (ctrl.sync),
    .en_i        (ctrl.en),
    .start_i     (ctrl.start),
    .size_i      (size),
    .count_i     (count),
    .active_o    (active_o),
    .len_o       (xfer_len_o),
    .len_valid_o (len_valid_o)
  );

  always_comb begin
    unique case (sel)
      A_CTRL:  rd_mux = ctrl_pack(ctrl);
      A_BASE:  rd_mux = DATA_W'(base);
      A_BLK:   rd_mux = {count, size};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata_o <= '0;
    else     reg_rdata_o <= rd_mux;
  end

  // R2: a control read-back never shows unmapped bits
  p_ctrl_rsvd_r2: assert property (@(posedge clk) disable iff (rst)
    (sel == A_CTRL) |=> ((reg_rdata_o & ~CTRL_MASK) == '0));

  // R3: a base read-back never shows the upper byte
  p_base_hi_r3: assert property (@(posedge clk) disable iff (rst)
    (sel == A_BASE) |=> (reg_rdata_o[DATA_W-1:BASE_W] == '0));

  // R5: the channel is never active without its enable bit
  p_active_en_r5: assert property (@(posedge clk) disable iff (rst)
    active_o |-> ctrl.en);

  // R5 and R8: reserved mode neither activates nor yields a length
  p_rsvd_mode_r8: assert property (@(posedge clk) disable iff (rst)
    (ctrl.sync == SM_RSVD) |-> (!active_o && !len_valid_o));
endmodule

// File: tb/dma_chan_regs_bench.sv
module dma_chan_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        done = 1'b0;
  logic        active;
  logic [31:0] xlen;
  logic        lvalid;

  int checks = 0;
  int failures = 0;
  logic finished = 1'b0;

  logic [31:0] m_ctrl, m_base, m_blk;

  always #2.5 clk = ~clk;

  dma_chan_regs u_dma_chan_regs (
    .clk(clk), .rst(rst), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .done_i(done),
    .active_o(active), .xfer_len_o(xlen), .len_valid_o(lvalid)
  );

  function automatic logic exp_active(logic [31:0] c);
    logic [1:0] m = c[10:9];
    if (!c[24]) return 1'b0;
    if (m == 2'd0) return c[28];
    return (m == 2'd1 || m == 2'd2);
  endfunction

  function automatic logic exp_valid(logic [31:0] c);
    return (c[10:9] == 2'd0 || c[10:9] == 2'd1);
  endfunction

  function automatic logic [31:0] exp_len(logic [31:0] c, logic [31:0] b);
    if (c[10:9] == 2'd0) return {16'd0, b[15:0]};
    if (c[10:9] == 2'd1) return b[15:0] * b[31:16];
    return 32'd0;
  endfunction

  function automatic logic [31:0] exp_read(logic [1:0] a);
    case (a)
      2'd0: return m_ctrl;
      2'd1: return m_base;
      2'd2: return m_blk;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_status(string req);
    chk({req, " active"}, {31'd0, active}, {31'd0, exp_active(m_ctrl)});
    chk({req, " valid"}, {31'd0, lvalid}, {31'd0, exp_valid(m_ctrl)});
    chk({req, " len"}, xlen, exp_len(m_ctrl, m_blk));
  endtask

  // One bus cycle, called at a negedge; checks at the following negedge
  task automatic cyc(logic w, logic [1:0] a, logic [31:0] d, logic dn, string req);
    logic [31:0] exp_rd;
    we = w; addr = a; wdata = d; done = dn;
    exp_rd = exp_read(a);   // R12: read shows contents before this cycle's write
    @(posedge clk);
    if (w) begin
      case (a)
        2'd0: m_ctrl = d & 32'h7177_0703;
        2'd1: m_base = {8'd0, d[23:0]};
        2'd2: m_blk  = d;
        default: ;
      endcase
    end
    if (dn) m_ctrl = m_ctrl & ~32'h1100_0000;
    @(negedge clk);
    chk({req, " rdata R12"}, rdata, exp_rd);
    check_status(req);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    m_ctrl = '0; m_base = '0; m_blk = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check_status("R1");
    cyc(0, 2'd0, 0, 0, "R1 ctrl");
    cyc(0, 2'd1, 0, 0, "R1 base");
    cyc(0, 2'd2, 0, 0, "R1 blk");
    // R2: all ones masked
    cyc(1, 2'd0, 32'hFFFF_FFFF, 0, "R2 write");
    cyc(0, 2'd0, 0, 0, "R2 readback");
    chk("R2 mask", rdata, 32'h7177_0703);
    // R3: upper base byte dropped
    cyc(1, 2'd1, 32'hABCD_EF12, 0, "R3 write");
    cyc(0, 2'd1, 0, 0, "R3 readback");
    chk("R3 base", rdata, 32'h00CD_EF12);
    // R4 and R7: max size and count product
    cyc(1, 2'd2, 32'hFFFF_FFFF, 0, "R4 write");
    cyc(0, 2'd2, 0, 0, "R4 readback");
    chk("R4 blk", rdata, 32'hFFFF_FFFF);
    cyc(1, 2'd0, 32'h0100_0200, 0, "R7 request");
    chk("R7 len", xlen, 32'hFFFE_0001);
    chk("R5 request active", {31'd0, active}, 32'd1);
    // R6 and R5: manual mode needs trigger
    cyc(1, 2'd2, 32'h0003_0040, 0, "R6 blk");
    cyc(1, 2'd0, 32'h0100_0000, 0, "R5 manual no trigger");
    chk("R5 manual idle", {31'd0, active}, 32'd0);
    chk("R6 len", xlen, 32'h0000_0040);
    cyc(1, 2'd0, 32'h1100_0000, 0, "R5 manual trigger");
    chk("R5 manual armed", {31'd0, active}, 32'd1);
    // R8: linked list and reserved mode
    cyc(1, 2'd0, 32'h0100_0400, 0, "R8 list");
    chk("R8 list valid", {31'd0, lvalid}, 32'd0);
    chk("R5 list active", {31'd0, active}, 32'd1);
    cyc(1, 2'd0, 32'h1100_0600, 0, "R8 reserved");
    chk("R5 reserved active", {31'd0, active}, 32'd0);
    chk("R8 reserved valid", {31'd0, lvalid}, 32'd0);
    // R9: done clears enable and trigger only
    cyc(1, 2'd0, 32'h7177_0303, 0, "R9 setup");
    cyc(0, 2'd3, 0, 1, "R9 done");
    cyc(0, 2'd0, 0, 0, "R9 readback");
    chk("R9 fields", rdata, 32'h6077_0303);
    // R10: done beats same-cycle write
    cyc(1, 2'd0, 32'h1100_0001, 1, "R10 collide");
    cyc(0, 2'd0, 0, 0, "R10 readback");
    chk("R10 ctrl", rdata, 32'h0000_0001);
    // R11: address 3 ignored
    cyc(1, 2'd3, 32'hFFFF_FFFF, 0, "R11 write");
    cyc(0, 2'd3, 0, 0, "R11 read");
    chk("R11 zero", rdata, 32'd0);
    cyc(0, 2'd1, 0, 0, "R11 base kept");
    chk("R11 base", rdata, 32'h00CD_EF12);
    // Random mix, every cycle checked against the model
    for (int i = 0; i < 400; i++) begin
      logic [31:0] d;
      d = $urandom;
      if ((i % 7) == 0) d[28:24] = 5'h11;
      cyc(($urandom % 3) != 0, 2'($urandom), d, ($urandom % 6) == 0, "R12 random");
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule